// File: doc/BRIEF.md
# Trap Entry State Sequencer

This block keeps the trap-related processor state of a register-window processor and applies, in one clock edge, every update that taking a trap requires. It holds the trap-enable, supervisor and previous-supervisor flags, the current window pointer, the interrupt mask level, the trap base register (base address and trap-type field), and the program counter pair (PC and next PC). A trap request arrives with an 8-bit type code, a class flag (synchronous or asynchronous) and a flag marking a reset trap.

When a trap is accepted, the block clears trap-enable and saves the supervisor flag into the previous-supervisor flag. It then sets supervisor, moves the window pointer down by one with wrap-around, and records the type code. It redirects PC/nPC to the handler slot, or to 0/4 for a reset. Nothing else is saved. Every change can be undone by the handler. The return pair is presented on a one-cycle write port, tagged with the new window index, so the enclosing core can store it in the first two locals of the trap window. A synchronous trap that arrives while traps are disabled does not vector. It puts the block into a sticky error mode instead.

A simple step input advances PC/nPC to model instruction flow. A control-write port models the status and base-register write instructions.

Top module: `trap_entry_seq`

## Requirements
- R1: While rst_n is low at a clock edge the state becomes: trap-enable 0, supervisor 1, previous-supervisor 0, window pointer 0, mask level 0, trap base register all zero, PC 0, nPC 4, error mode 0, trap_taken 0, win_we 0.
- R2: On an accepted trap, trap-enable becomes 0, previous-supervisor takes the old supervisor value, supervisor becomes 1, and the mask level keeps its value.
- R3: On an accepted trap, the window pointer becomes the old value minus one, and 0 wraps to NWIN-1.
- R4: On an accepted trap, bits [11:4] of the trap base register take the trap code. Bits [31:12] keep the base address, and bits [3:0] read zero.
- R5: On an accepted non-reset trap, PC becomes {base, code, 4'b0000} and nPC becomes that value plus 4. On an accepted reset trap, PC becomes 0 and nPC becomes 4.
- R6: trap_taken and win_we are high for exactly the one cycle after the accepting edge, and win_idx equals the new window pointer. For a synchronous trap, win_l1/win_l2 are the old PC and nPC. For an asynchronous trap, they are the old nPC and nPC+4.
- R7: An asynchronous, non-reset trap request while trap-enable is 0 is ignored: no state changes and no trap_taken.
- R8: A synchronous, non-reset trap request while trap-enable is 0 sets error mode and changes no other state. Error mode then stays set, and every non-reset trap request, step and control write is ignored, until rst_n or a reset trap.
- R9: A reset trap (trap_is_reset=1) is accepted whatever the trap-enable and error-mode values, and it clears error mode.
- R10: With no trap accepted and no error mode, step=1 moves PC to nPC and nPC to nPC+4.
- R11: With no trap accepted and no error mode, ctl_wr=1 loads trap-enable, supervisor, window pointer, mask level and base address from the wr_* inputs. A control write in the same cycle as an accepted trap is discarded.
- R12: A synchronous trap accepted together with step=1 suppresses the step. An asynchronous trap accepted together with step=1 still saves the old nPC and nPC+4, and PC/nPC go to the handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap request this cycle |
| trap_code | input | 8 | Trap type code |
| trap_sync | input | 1 | 1 = synchronous trap, 0 = asynchronous |
| trap_is_reset | input | 1 | Request is a reset trap |
| step | input | 1 | Advance PC/nPC by one instruction |
| ctl_wr | input | 1 | Control write strobe |
| wr_et | input | 1 | Trap-enable value to write |
| wr_s | input | 1 | Supervisor value to write |
| wr_cwp | input | 3 | Window pointer value to write |
| wr_pil | input | 4 | Mask level value to write |
| wr_base | input | 20 | Trap base address field to write |
| et_o | output | 1 | Trap-enable flag |
| s_o | output | 1 | Supervisor flag |
| ps_o | output | 1 | Previous-supervisor flag |
| cwp_o | output | 3 | Current window pointer |
| pil_o | output | 4 | Interrupt mask level |
| tbr_o | output | 32 | Trap base register {base, type, 0000} |
| pc_o | output | 32 | Program counter |
| npc_o | output | 32 | Next program counter |
| err_o | output | 1 | Error mode |
| trap_taken | output | 1 | One-cycle pulse after a trap is accepted |
| win_we | output | 1 | Window local write strobe |
| win_idx | output | 3 | Window receiving the saved pair |
| win_l1 | output | 32 | Value for the first local register |
| win_l2 | output | 32 | Value for the second local register |

## Verification
A trap can be accepted in the same cycle as an instruction step or a control write, and these coincidences are where the design decides priority. The bench asserts step together with synchronous and asynchronous traps. For a synchronous trap it checks that the saved pair is the unadvanced PC/nPC. For an asynchronous trap it checks that the saved pair is nPC/nPC+4. In both cases PC lands on the handler slot rather than on the stepped address. A control write issued in the trap cycle is judged at the ports: the mask level and window pointer must show the trap result, not the written values.

// File: rtl/tes_pkg.sv
// Shared definitions for the trap entry sequencer.
// Assumes instructions are 4 bytes and handler slots are 16 bytes apart.
package tes_pkg;
    localparam int SLOT_SHIFT = 4;
    localparam int INSN_BYTES = 4;

    // Outcome of a trap request in the current cycle.
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_TAKE  = 2'd1,
        ACT_ERROR = 2'd2
    } act_e;
endpackage

// File: rtl/tes_decide.sv
// Decides whether a trap request vectors, raises error mode or is dropped.
// Purely combinational; assumes et/err are the registered current state.
module tes_decide (
    input  logic           trap_req,
    input  logic           trap_sync,
    input  logic           trap_is_reset,
    input  logic           et,
    input  logic           err,
    output tes_pkg::act_e  act
);
    import tes_pkg::*;

    // Priority: reset trap, then error-mode block, then enable check.
    always_comb begin
        act = ACT_NONE;
        if (trap_req) begin
            if (trap_is_reset)
                act = ACT_TAKE;
            else if (err)
                act = ACT_NONE;
            else if (et)
                act = ACT_TAKE;
            else if (trap_sync)
                act = ACT_ERROR;
            else
                act = ACT_NONE;
        end
    end
endmodule

// File: rtl/tes_status.sv
// Holds trap-enable, supervisor, previous-supervisor, window pointer,
// mask level and error mode. Trap entry makes only reversible changes.
// Assumes NWIN >= 2.
module tes_status #(
    parameter int NWIN  = 8,
    parameter int PIL_W = 4,
    localparam int CWP_W = $clog2(NWIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  tes_pkg::act_e      act,
    input  logic               ctl_wr,
    input  logic               wr_et,
    input  logic               wr_s,
    input  logic [CWP_W-1:0]   wr_cwp,
    input  logic [PIL_W-1:0]   wr_pil,
    output logic               et,
    output logic               s,
    output logic               ps,
    output logic [CWP_W-1:0]   cwp,
    output logic [PIL_W-1:0]   pil,
    output logic               err,
    output logic [CWP_W-1:0]   cwp_dec
);
    import tes_pkg::*;

    localparam int            LAST_I = NWIN - 1;
    localparam logic [CWP_W-1:0] LAST_WIN = LAST_I[CWP_W-1:0];

    // Window pointer minus one; a power-of-two count wraps naturally.
    generate
        if ((1 << CWP_W) == NWIN) begin : g_pow2
            always_comb cwp_dec = cwp - 1'b1;
        end else begin : g_any
            always_comb cwp_dec = (cwp == '0) ? LAST_WIN : cwp - 1'b1;
        end
    endgenerate

    // Status update: reset, trap entry, error entry or control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            et  <= 1'b0;
            s   <= 1'b1;
            ps  <= 1'b0;
            cwp <= '0;
            pil <= '0;
            err <= 1'b0;
        end else begin
            case (act)
                ACT_TAKE: begin
                    et  <= 1'b0;
                    ps  <= s;
                    s   <= 1'b1;
                    cwp <= cwp_dec;
                    err <= 1'b0;
                end
                ACT_ERROR: begin
                    err <= 1'b1;
                end
                default: begin
                    if (ctl_wr && !err) begin
                        et  <= wr_et;
                        s   <= wr_s;
                        cwp <= wr_cwp;
                        pil <= wr_pil;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tes_flow.sv
// Holds the trap base register and the PC/nPC pair. Trap entry redirects
// to the handler slot {base, type, 0000}; a reset trap goes to 0/4.
// Assumes ADDR_W > TT_W + SLOT_SHIFT.
module tes_flow #(
    parameter int ADDR_W = 32,
    parameter int TT_W   = 8,
    localparam int BASE_W = ADDR_W - TT_W - tes_pkg::SLOT_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  tes_pkg::act_e      act,
    input  logic               trap_is_reset,
    input  logic [TT_W-1:0]    trap_code,
    input  logic               step,
    input  logic               ctl_wr,
    input  logic [BASE_W-1:0]  wr_base,
    input  logic               err,
    output logic [ADDR_W-1:0]  tbr,
    output logic [ADDR_W-1:0]  pc,
    output logic [ADDR_W-1:0]  npc
);
    import tes_pkg::*;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [BASE_W-1:0] base_q;
    logic [TT_W-1:0]   tt_q;
    logic [ADDR_W-1:0] handler;

    // Handler slot address built from the current base and the new code.
    always_comb handler = {base_q, trap_code, {SLOT_SHIFT{1'b0}}};

    // Register image seen by the outside.
    always_comb tbr = {base_q, tt_q, {SLOT_SHIFT{1'b0}}};

    // Base/type update and program-counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            tt_q   <= '0;
            pc     <= '0;
            npc    <= STEP;
        end else begin
            case (act)
                ACT_TAKE: begin
                    tt_q <= trap_code;
                    if (trap_is_reset) begin
                        pc  <= '0;
                        npc <= STEP;
                    end else begin
                        pc  <= handler;
                        npc <= handler + STEP;
                    end
                end
                ACT_ERROR: begin
                    tt_q <= tt_q;
                end
                default: begin
                    if (!err) begin
                        if (ctl_wr)
                            base_q <= wr_base;
                        if (step) begin
                            pc  <= npc;
                            npc <= npc + STEP;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tes_winport.sv
// Presents the saved return pair for the new window's first two locals.
// Synchronous traps save PC/nPC; asynchronous ones save nPC/nPC+4.
module tes_winport #(
    parameter int ADDR_W = 32,
    parameter int CWP_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  tes_pkg::act_e      act,
    input  logic               trap_sync,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [ADDR_W-1:0]  npc,
    input  logic [CWP_W-1:0]   cwp_new,
    output logic               taken,
    output logic               we,
    output logic [CWP_W-1:0]   idx,
    output logic [ADDR_W-1:0]  l1,
    output logic [ADDR_W-1:0]  l2
);
    import tes_pkg::*;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    // One-cycle write strobe with the return pair chosen by trap class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken <= 1'b0;
            we    <= 1'b0;
            idx   <= '0;
            l1    <= '0;
            l2    <= '0;
        end else if (act == ACT_TAKE) begin
            taken <= 1'b1;
            we    <= 1'b1;
            idx   <= cwp_new;
            l1    <= trap_sync ? pc  : npc;
            l2    <= trap_sync ? npc : npc + STEP;
        end else begin
            taken <= 1'b0;
            we    <= 1'b0;
        end
    end
endmodule

// File: rtl/trap_entry_seq.sv
// Top of the trap entry sequencer: decision, status, flow and window port.
// Assumes one trap request at most per cycle and NWIN >= 2.
module trap_entry_seq #(
    parameter int NWIN   = 8,
    parameter int ADDR_W = 32,
    parameter int TT_W   = 8,
    parameter int PIL_W  = 4,
    localparam int CWP_W  = $clog2(NWIN),
    localparam int BASE_W = ADDR_W - TT_W - tes_pkg::SLOT_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_req,
    input  logic [TT_W-1:0]    trap_code,
    input  logic               trap_sync,
    input  logic               trap_is_reset,
    input  logic               step,
    input  logic               ctl_wr,
    input  logic               wr_et,
    input  logic               wr_s,
    input  logic [CWP_W-1:0]   wr_cwp,
    input  logic [PIL_W-1:0]   wr_pil,
    input  logic [BASE_W-1:0]  wr_base,
    output logic               et_o,
    output logic               s_o,
    output logic               ps_o,
    output logic [CWP_W-1:0]   cwp_o,
    output logic [PIL_W-1:0]   pil_o,
    output logic [ADDR_W-1:0]  tbr_o,
    output logic [ADDR_W-1:0]  pc_o,
    output logic [ADDR_W-1:0]  npc_o,
    output logic               err_o,
    output logic               trap_taken,
    output logic               win_we,
    output logic [CWP_W-1:0]   win_idx,
    output logic [ADDR_W-1:0]  win_l1,
    output logic [ADDR_W-1:0]  win_l2
);
    tes_pkg::act_e    act;
    logic [CWP_W-1:0] cwp_dec;

    tes_decide u_decide (
        .trap_req      (trap_req),
        .trap_sync     (trap_sync),
        .trap_is_reset (trap_is_reset),
        .et            (et_o),
        .err           (err_o),
        .act           (act)
    );

    tes_status #(.NWIN(NWIN), .PIL_W(PIL_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .ctl_wr  (ctl_wr),
        .wr_et   (wr_et),
        .wr_s    (wr_s),
        .wr_cwp  (wr_cwp),
        .wr_pil  (wr_pil),
        .et      (et_o),
        .s       (s_o),
        .ps      (ps_o),
        .cwp     (cwp_o),
        .pil     (pil_o),
        .err     (err_o),
        .cwp_dec (cwp_dec)
    );

    tes_flow #(.ADDR_W(ADDR_W), .TT_W(TT_W)) u_flow (
        .clk           (clk),
        .rst_n         (rst_n),
        .act           (act),
        .trap_is_reset (trap_is_reset),
        .trap_code     (trap_code),
        .step          (step),
        .ctl_wr        (ctl_wr),
        .wr_base       (wr_base),
        .err           (err_o),
        .tbr           (tbr_o),
        .pc            (pc_o),
        .npc           (npc_o)
    );

    tes_winport #(.ADDR_W(ADDR_W), .CWP_W(CWP_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .trap_sync (trap_sync),
        .pc        (pc_o),
        .npc       (npc_o),
        .cwp_new   (cwp_dec),
        .taken     (trap_taken),
        .we        (win_we),
        .idx       (win_idx),
        .l1        (win_l1),
        .l2        (win_l2)
    );
endmodule

// File: rtl/trap_entry_seq_chk.sv
// Temporal checks on the trap entry sequencer ports, attached by bind.
module trap_entry_seq_chk #(
    parameter int NWIN   = 8,
    parameter int ADDR_W = 32,
    parameter int PIL_W  = 4,
    localparam int CWP_W = $clog2(NWIN)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trap_is_reset,
    input logic               et_o,
    input logic               s_o,
    input logic               ps_o,
    input logic [CWP_W-1:0]   cwp_o,
    input logic [PIL_W-1:0]   pil_o,
    input logic [ADDR_W-1:0]  pc_o,
    input logic [ADDR_W-1:0]  npc_o,
    input logic               err_o,
    input logic               trap_taken,
    input logic               win_we,
    input logic [CWP_W-1:0]   win_idx
);
    localparam int            LAST_I = NWIN - 1;
    localparam logic [CWP_W-1:0] LAST_WIN = LAST_I[CWP_W-1:0];

    // R2
    et_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (!et_o && s_o && ps_o == $past(s_o)));

    // R2
    pil_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> pil_o == $past(pil_o));

    // R3
    cwp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> cwp_o == (($past(cwp_o) == '0) ? LAST_WIN
                                                      : $past(cwp_o) - 1'b1));

    // R5
    npc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> npc_o == pc_o + 32'd4);

    // R6
    win_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (win_we && win_idx == cwp_o));

    // R7
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> ($past(et_o) || $past(trap_is_reset)));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (err_o || trap_taken));
endmodule

bind trap_entry_seq trap_entry_seq_chk #(.NWIN(NWIN), .ADDR_W(ADDR_W), .PIL_W(PIL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_is_reset (trap_is_reset),
    .et_o          (et_o),
    .s_o           (s_o),
    .ps_o          (ps_o),
    .cwp_o         (cwp_o),
    .pil_o         (pil_o),
    .pc_o          (pc_o),
    .npc_o         (npc_o),
    .err_o         (err_o),
    .trap_taken    (trap_taken),
    .win_we        (win_we),
    .win_idx       (win_idx)
);

// File: tb/trap_entry_seq_tb.sv
module trap_entry_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        trap_req, trap_sync, trap_is_reset, step, ctl_wr;
    logic [7:0]  trap_code;
    logic        wr_et, wr_s;
    logic [2:0]  wr_cwp;
    logic [3:0]  wr_pil;
    logic [19:0] wr_base;
    logic        et_o, s_o, ps_o, err_o, trap_taken, win_we;
    logic [2:0]  cwp_o, win_idx;
    logic [3:0]  pil_o;
    logic [31:0] tbr_o, pc_o, npc_o, win_l1, win_l2;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    trap_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_code(trap_code),
        .trap_sync(trap_sync), .trap_is_reset(trap_is_reset), .step(step),
        .ctl_wr(ctl_wr), .wr_et(wr_et), .wr_s(wr_s), .wr_cwp(wr_cwp),
        .wr_pil(wr_pil), .wr_base(wr_base), .et_o(et_o), .s_o(s_o),
        .ps_o(ps_o), .cwp_o(cwp_o), .pil_o(pil_o), .tbr_o(tbr_o),
        .pc_o(pc_o), .npc_o(npc_o), .err_o(err_o), .trap_taken(trap_taken),
        .win_we(win_we), .win_idx(win_idx), .win_l1(win_l1), .win_l2(win_l2)
    );

    typedef struct packed {
        logic        et;
        logic        s;
        logic [2:0]  cwp;
        logic [3:0]  pil;
        logic [19:0] base;
        logic [2:0]  nstep;
        logic [7:0]  code;
        logic        sync;
        logic        rst;
        logic        stepw;
        logic        exp_take;
        logic        exp_err;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 3'd3, 4'h5, 20'hABCDE, 3'd2, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 3'd0, 4'h0, 20'h12345, 3'd1, 8'h80, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd5, 4'hF, 20'h00001, 3'd3, 8'h2A, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        '{1'b0, 1'b1, 3'd2, 4'h3, 20'h55555, 3'd1, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 3'd4, 4'h1, 20'h0F0F0, 3'd2, 8'h09, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b0, 3'd6, 4'h2, 20'h77777, 3'd1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 3'd7, 4'h9, 20'hFFFFF, 3'd0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b0, 3'd1, 4'h0, 20'h00000, 3'd4, 8'h03, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        trap_req = 0; trap_code = 0; trap_sync = 0; trap_is_reset = 0;
        step = 0; ctl_wr = 0; wr_et = 0; wr_s = 0; wr_cwp = 0; wr_pil = 0;
        wr_base = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst_n = 0;
        @(negedge clk); rst_n = 1;
    endtask

    task automatic write_ctl(input logic e, input logic sv, input logic [2:0] w,
                             input logic [3:0] p, input logic [19:0] b);
        @(negedge clk);
        ctl_wr = 1; wr_et = e; wr_s = sv; wr_cwp = w; wr_pil = p; wr_base = b;
        @(negedge clk); idle();
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); step = 1;
            @(negedge clk); step = 0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        do_reset();
        chk("R1", "et", 32'(et_o), 0);
        chk("R1", "s", 32'(s_o), 1);
        chk("R1", "ps", 32'(ps_o), 0);
        chk("R1", "cwp", 32'(cwp_o), 0);
        chk("R1", "pil", 32'(pil_o), 0);
        chk("R1", "tbr", tbr_o, 0);
        chk("R1", "pc", pc_o, 0);
        chk("R1", "npc", npc_o, 4);
        chk("R1", "err", 32'(err_o), 0);
        chk("R1", "taken", 32'({trap_taken, win_we}), 0);

        // R10 stepping
        steps(3);
        chk("R10", "pc", pc_o, 12);
        chk("R10", "npc", npc_o, 16);

        // Vector table: R2..R9, R12
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            logic [31:0] p0, hdl, epc, el1, el2;
            v = VEC[k];
            do_reset();
            write_ctl(v.et, v.s, v.cwp, v.pil, v.base);
            steps(int'(v.nstep));
            p0  = 32'(v.nstep) * 4;
            hdl = {v.base, v.code, 4'h0};
            @(negedge clk);
            trap_req = 1; trap_code = v.code; trap_sync = v.sync;
            trap_is_reset = v.rst; step = v.stepw;
            @(negedge clk); idle();
            if (v.exp_take) begin
                epc = v.rst ? 32'd0 : hdl;
                el1 = v.sync ? p0 : p0 + 4;
                el2 = v.sync ? p0 + 4 : p0 + 8;
                chk("R6", "taken", 32'(trap_taken), 1);
                chk("R2", "et", 32'(et_o), 0);
                chk("R2", "s", 32'(s_o), 1);
                chk("R2", "ps", 32'(ps_o), 32'(v.s));
                chk("R2", "pil", 32'(pil_o), 32'(v.pil));
                chk("R3", "cwp", 32'(cwp_o), 32'(3'(v.cwp - 3'd1)));
                chk("R4", "tbr", tbr_o, hdl);
                chk(v.rst ? "R9" : "R5", "pc", pc_o, epc);
                chk("R5", "npc", npc_o, epc + 4);
                chk("R6", "we", 32'(win_we), 1);
                chk("R6", "idx", 32'(win_idx), 32'(3'(v.cwp - 3'd1)));
                chk(v.stepw ? "R12" : "R6", "l1", win_l1, el1);
                chk(v.stepw ? "R12" : "R6", "l2", win_l2, el2);
                @(negedge clk);
                chk("R6", "pulse end", 32'({trap_taken, win_we}), 0);
            end else begin
                chk(v.exp_err ? "R8" : "R7", "taken", 32'(trap_taken), 0);
                chk(v.exp_err ? "R8" : "R7", "err", 32'(err_o), 32'(v.exp_err));
                chk(v.exp_err ? "R8" : "R7", "et", 32'(et_o), 32'(v.et));
                chk(v.exp_err ? "R8" : "R7", "s", 32'(s_o), 32'(v.s));
                chk(v.exp_err ? "R8" : "R7", "cwp", 32'(cwp_o), 32'(v.cwp));
                chk(v.exp_err ? "R8" : "R7", "tbr", tbr_o, {v.base, 8'h00, 4'h0});
                chk(v.exp_err ? "R8" : "R7", "pc", pc_o, p0);
            end
        end

        // R11 control write with an accepted trap is discarded
        do_reset();
        write_ctl(1'b1, 1'b0, 3'd4, 4'h6, 20'h00100);
        chk("R11", "write pil", 32'(pil_o), 6);
        @(negedge clk);
        trap_req = 1; trap_code = 8'h44; trap_sync = 1;
        ctl_wr = 1; wr_et = 1; wr_cwp = 3'd1; wr_pil = 4'hC; wr_base = 20'h00F00;
        @(negedge clk); idle();
        chk("R11", "pil kept", 32'(pil_o), 6);
        chk("R11", "cwp trap", 32'(cwp_o), 3);
        chk("R11", "tbr", tbr_o, {20'h00100, 8'h44, 4'h0});

        // R8 sticky error blocks writes, steps and non-reset traps
        do_reset();
        @(negedge clk); trap_req = 1; trap_sync = 1; trap_code = 8'h07;
        @(negedge clk); idle();
        chk("R8", "err set", 32'(err_o), 1);
        write_ctl(1'b1, 1'b0, 3'd5, 4'h2, 20'h00001);
        chk("R8", "write ignored et", 32'(et_o), 0);
        chk("R8", "write ignored cwp", 32'(cwp_o), 0);
        steps(1);
        chk("R8", "step ignored", pc_o, 0);
        @(negedge clk); trap_req = 1; trap_sync = 0; trap_code = 8'h08;
        @(negedge clk); idle();
        chk("R8", "no take", 32'(trap_taken), 0);
        chk("R8", "still err", 32'(err_o), 1);

        // R9 reset trap leaves error mode
        @(negedge clk); trap_req = 1; trap_is_reset = 1; trap_code = 8'h00;
        @(negedge clk); idle();
        chk("R9", "taken", 32'(trap_taken), 1);
        chk("R9", "err clear", 32'(err_o), 0);
        chk("R9", "pc", pc_o, 0);
        chk("R3", "wrap", 32'(cwp_o), 7);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule